// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs the external bus cycles of a small controller that shares one set of lines between address and data. The core clock is four times the bus phase rate. Each core clock is therefore one quarter of a bus period, called a tick here. Every strobe edge is placed on that tick grid, counted from the point where the address-latch strobe falls. A read and a write use different strobe offsets and different strobe widths.

A client offers a request with an address, write data, a read/write flag and a wait-state count. The sequencer accepts the request only while it is idle. It then drives an address phase, followed by a read or a write strobe phase, and ends with one `done` tick. For a read, that tick also returns the captured data. The strobe can be lengthened in two ways. The programmed wait-state count adds a fixed extension. An external ready input, sampled through a two-flop synchroniser, adds one full bus period each time it is found low at a decision tick.

The pads are out of scope, so the bus is split into three ports: an output value `ad_out`, an output enable `ad_oe` and an input value `ad_in`.

Top module: `bus_seq`

## Requirements
- R1: While reset is asserted and after it is released, `ale` is low, `rd_n` and `wr_n` are high, `ad_oe` is low, `done` is low and `req_ready` is high.
- R2: In each cycle, `ale` is high for exactly 2 ticks. `ad_oe` is high and `ad_out` carries the request address on both of those ticks and on the one tick after `ale` falls.
- R3: In a read, `rd_n` falls 1 tick after `ale` falls. With ready high, `rd_n` then stays low for 2 + 4*W ticks, where W is the wait-state count. `rd_n` and `wr_n` are never low together.
- R4: Read data on `ad_in` is captured at the tick on which `rd_n` rises. It is shown on `rdata` in the tick where `done` is high.
- R5: `ad_oe` is low for as long as `rd_n` is low. It also stays low for the 4 ticks after `rd_n` rises.
- R6: In a write, `wr_n` falls 2 ticks after `ale` falls. With ready high, `wr_n` then stays low for 3 + 4*W ticks.
- R7: `ad_out` carries the write data, with `ad_oe` high, from 1 tick before `wr_n` falls until 1 tick after `wr_n` rises. It does not change during that span.
- R8: The 3-bit `wait_cnt` is latched when a request is accepted. Each wait state lengthens the strobe by 4 ticks. Changing `wait_cnt` after acceptance has no effect on the cycle in progress.
- R9: `ready` passes through a two-flop synchroniser. The synchronised value is examined on the last tick of the base strobe and on the last tick of each extension period. Each low result adds 4 ticks to the strobe.
- R10: A low level on `ready` that has been replaced by a high level before the first decision tick's synchronised sample does not lengthen the strobe.
- R11: A request is accepted only in a tick where `req_ready` is high. A request held while the block is busy starts no extra cycle.
- R12: `done` is high for exactly one tick, the last tick of the cycle. A request held high in that tick is accepted one tick later, so `ale` rises 2 ticks after the `done` tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request valid |
| req_we | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | BUS_W | Request address |
| req_wdata | input | BUS_W | Write data |
| wait_cnt | input | WSW | Wait-state count for the request |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| done | output | 1 | Final tick of a cycle |
| rdata | output | BUS_W | Captured read data |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | BUS_W | Value driven on the shared bus |
| ad_oe | output | 1 | Bus output enable |
| ad_in | input | BUS_W | Value sampled from the shared bus |
| ready | input | 1 | Asynchronous ready, low stretches the strobe |

## Verification
The assertions assume that `rst_n` is low at the first clock edge. Their `$past` windows therefore see reset values, never unknown ones. They also assume that request fields stay stable while `req` is high in an idle tick. The bench changes every input on the falling clock edge and alters request fields only after acceptance or in the `done` tick. It moves `ready` only after a strobe has been seen on the ports. This lets its expected strobe width be computed from the synchroniser delay and the decision-tick spacing.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  // Quarter-period ticks per bus period.
  localparam int unsigned TICKS_PER_PERIOD = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ALE,    // address phase, latch strobe high
    ST_AHOLD,  // address still driven, latch strobe low
    ST_RSTB,   // base read strobe
    ST_REXT,   // ready extension of read strobe
    ST_RREC,   // bus turnaround after read
    ST_WSET,   // write data setup
    ST_WSTB,   // base write strobe
    ST_WEXT,   // ready extension of write strobe
    ST_WHOLD   // write data hold
  } seq_state_e;

endpackage

// File: rtl/bus_seq_sync.sv
module bus_seq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/bus_seq_timer.sv
module bus_seq_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/bus_seq_dpath.sv
module bus_seq_dpath #(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [BUS_W-1:0] addr_in,
  input  logic [BUS_W-1:0] wdata_in,
  input  logic             sel_wdata,
  input  logic             capture,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] bus_out,
  output logic [BUS_W-1:0] rdata
);

  logic [BUS_W-1:0] addr_q, wdata_q, rdata_q;
  logic [BUS_W-1:0] addr_d, wdata_d, rdata_d;

  always_comb begin
    addr_d  = accept  ? addr_in  : addr_q;
    wdata_d = accept  ? wdata_in : wdata_q;
    rdata_d = capture ? bus_in   : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_out = sel_wdata ? wdata_q : addr_q;
  assign rdata   = rdata_q;

endmodule

// File: rtl/bus_seq.sv
module bus_seq
  import bus_seq_pkg::*;
#(
  parameter int BUS_W       = 16,
  parameter int WSW         = 3,
  parameter int WAIT_UNIT   = TICKS_PER_PERIOD,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  input  logic [WSW-1:0]   wait_cnt,
  output logic             req_ready,
  output logic             done,
  output logic [BUS_W-1:0] rdata,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  input  logic [BUS_W-1:0] ad_in,
  input  logic             ready
);

  localparam int MAX_STROBE = 3 + ((1 << WSW) - 1) * WAIT_UNIT;
  localparam int CNT_W      = $clog2(MAX_STROBE + 1);
  localparam logic [CNT_W-1:0] ALE_LAST = CNT_W'(1);
  localparam logic [CNT_W-1:0] EXT_LAST = CNT_W'(TICKS_PER_PERIOD - 1);
  localparam logic [CNT_W-1:0] RD_BASE  = CNT_W'(1);  // 2 ticks, minus one
  localparam logic [CNT_W-1:0] WR_BASE  = CNT_W'(2);  // 3 ticks, minus one

  seq_state_e       state_q, state_d;
  logic             we_q, we_d;
  logic [CNT_W-1:0] ext_q, ext_d;
  logic             accept, capture, tmr_load, tmr_exp, rdy_s, sel_wdata;
  logic [CNT_W-1:0] tmr_val;

  bus_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ready),
    .q     (rdy_s)
  );

  bus_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  bus_seq_dpath #(.BUS_W(BUS_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .addr_in   (req_addr),
    .wdata_in  (req_wdata),
    .sel_wdata (sel_wdata),
    .capture   (capture),
    .bus_in    (ad_in),
    .bus_out   (ad_out),
    .rdata     (rdata)
  );

  // Next-state and timer-load decisions.
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    accept   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          accept   = 1'b1;
          state_d  = ST_ALE;
          tmr_load = 1'b1;
          tmr_val  = ALE_LAST;
        end
      end
      ST_ALE: begin
        if (tmr_exp) begin
          state_d  = ST_AHOLD;
          tmr_load = 1'b1;
        end
      end
      ST_AHOLD: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (we_q) begin
            state_d = ST_WSET;
          end else begin
            state_d = ST_RSTB;
            tmr_val = RD_BASE + ext_q;
          end
        end
      end
      ST_RSTB, ST_REXT: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_val  = EXT_LAST;
          if (rdy_s) begin
            state_d = ST_RREC;
            capture = 1'b1;
          end else begin
            state_d = ST_REXT;
          end
        end
      end
      ST_RREC: begin
        if (tmr_exp) state_d = ST_IDLE;
      end
      ST_WSET: begin
        if (tmr_exp) begin
          state_d  = ST_WSTB;
          tmr_load = 1'b1;
          tmr_val  = WR_BASE + ext_q;
        end
      end
      ST_WSTB, ST_WEXT: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (rdy_s) begin
            state_d = ST_WHOLD;
          end else begin
            state_d = ST_WEXT;
            tmr_val = EXT_LAST;
          end
        end
      end
      ST_WHOLD: begin
        if (tmr_exp) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    we_d  = accept ? req_we : we_q;
    ext_d = accept ? (CNT_W'(wait_cnt) * CNT_W'(WAIT_UNIT)) : ext_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      ext_q   <= '0;
    end else begin
      state_q <= state_d;
      we_q    <= we_d;
      ext_q   <= ext_d;
    end
  end

  // Output decode from the registered state.
  always_comb begin
    ale       = (state_q == ST_ALE);
    rd_n      = !((state_q == ST_RSTB) || (state_q == ST_REXT));
    wr_n      = !((state_q == ST_WSTB) || (state_q == ST_WEXT));
    sel_wdata = (state_q == ST_WSET) || (state_q == ST_WSTB) ||
                (state_q == ST_WEXT) || (state_q == ST_WHOLD);
    ad_oe     = sel_wdata || (state_q == ST_ALE) || (state_q == ST_AHOLD);
    done      = tmr_exp && ((state_q == ST_RREC) || (state_q == ST_WHOLD));
    req_ready = (state_q == ST_IDLE);
  end

endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             req_ready,
  input logic             done,
  input logic             ale,
  input logic             rd_n,
  input logic             wr_n,
  input logic [BUS_W-1:0] ad_out,
  input logic             ad_oe
);

  assert_ale_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale ##1 !ale);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (ad_oe && $stable(ad_out)));

  assert_rd_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> (!$past(ale) && $past(ale, 2)));

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_no_drive_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> !ad_oe ##1 !ad_oe ##1 !ad_oe ##1 !ad_oe);

  assert_wr_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> (!$past(ale) && !$past(ale, 2) && $past(ale, 3)));

  assert_wdata_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !$past(wr_n)) |-> (ad_oe && $stable(ad_out)));

  assert_wdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (ad_oe && $stable(ad_out)));

  assert_accept_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> ($past(req) && $past(req_ready)));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);

endmodule

bind bus_seq bus_seq_chk #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .req_ready (req_ready),
  .done      (done),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .ad_out    (ad_out),
  .ad_oe     (ad_oe)
);

// File: tb/bus_seq_tb.sv
module bus_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_we, ready;
  logic [15:0] req_addr, req_wdata, bus_rd_val;
  logic [2:0]  wait_cnt;
  logic        req_ready, done, ale, rd_n, wr_n, ad_oe;
  logic [15:0] rdata, ad_out;

  typedef struct {
    logic        we;
    logic [15:0] addr;
    logic [15:0] data;
    int          width;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  bus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .wait_cnt(wait_cnt),
    .req_ready(req_ready), .done(done), .rdata(rdata), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(bus_rd_val), .ready(ready)
  );

  task automatic chk(input bit ok, input string r, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Strobe width from base length and the ready release point L
  // (negedges after the first strobe tick); L < 0 keeps ready high.
  function automatic int exp_width(input logic we, input int ws, input int L);
    int b = (we ? 3 : 2) + 4 * ws;
    int k = 0;
    if (L >= 0) begin
      for (int j = 0; j < 64; j++) begin
        if (b + 4 * j - 2 <= L) k++;
        else break;
      end
    end
    return b + 4 * k;
  endfunction

  task automatic push_exp(input logic we, input logic [15:0] a, input logic [15:0] d,
                          input int ws, input int L);
    exp_t e;
    e.we = we; e.addr = a; e.data = d; e.width = exp_width(we, ws, L);
    exp_q.push_back(e);
  endtask

  task automatic do_txn(input logic we, input logic [15:0] a, input logic [15:0] d,
                        input int ws, input int L);
    push_exp(we, a, d, ws, L);
    bus_rd_val = d;
    wait_cnt   = 3'(ws);
    if (L >= 0) ready = 1'b0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    wait_cnt = 3'(ws + 2);  // R8: late change must not matter
    if (L >= 0) begin
      while (rd_n && wr_n) @(negedge clk);
      repeat (L) @(negedge clk);
      ready = 1'b1;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops one expected item per observed cycle.
  initial begin
    exp_t e;
    int   n, w;
    forever begin
      @(negedge clk);
      if (rst_n && ale) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected cycle", 1, 0);
        end else begin
          e = exp_q.pop_front();
          n = 0;
          while (ale) begin
            chk(ad_oe && ad_out == e.addr, "R2 address during ale", int'(ad_out), int'(e.addr));
            n++;
            @(negedge clk);
          end
          chk(n == 2, "R2 ale width", n, 2);
          chk(ad_oe && ad_out == e.addr, "R2 address hold", int'(ad_out), int'(e.addr));
          @(negedge clk);
          if (!e.we) begin
            chk(!rd_n, "R3 rd offset", int'(rd_n), 0);
            w = 0;
            while (!rd_n) begin
              chk(!ad_oe, "R5 no drive while rd low", int'(ad_oe), 0);
              w++;
              @(negedge clk);
            end
            chk(w == e.width, "R3 R8 R9 R10 rd width", w, e.width);
            for (int i = 0; i < 4; i++) begin
              chk(!ad_oe, "R5 turnaround", int'(ad_oe), 0);
              chk(done == (i == 3), "R12 done timing", int'(done), int'(i == 3));
              if (i == 3) chk(rdata == e.data, "R4 read data", int'(rdata), int'(e.data));
              @(negedge clk);
            end
          end else begin
            chk(wr_n && ad_oe && ad_out == e.data, "R7 write setup", int'(ad_out), int'(e.data));
            @(negedge clk);
            chk(!wr_n, "R6 wr offset", int'(wr_n), 0);
            w = 0;
            while (!wr_n) begin
              chk(ad_oe && ad_out == e.data, "R7 write data", int'(ad_out), int'(e.data));
              w++;
              @(negedge clk);
            end
            chk(w == e.width, "R6 R8 R9 R10 wr width", w, e.width);
            chk(ad_oe && ad_out == e.data, "R7 write hold", int'(ad_out), int'(e.data));
            chk(done, "R12 done on write", int'(done), 1);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int gap;
    rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    wait_cnt = 3'd1; ready = 1'b1; bus_rd_val = '0;
    repeat (2) @(negedge clk);
    // R1 during reset
    chk(!ale && rd_n && wr_n && !ad_oe, "R1 in reset", int'({ale, rd_n, wr_n, ad_oe}), 6);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ale && rd_n && wr_n && !ad_oe && !done, "R1 after reset",
        int'({ale, rd_n, wr_n, ad_oe, done}), 12);
    chk(req_ready, "R1 idle ready", int'(req_ready), 1);

    // R3 R4 R5: plain read, one wait state
    do_txn(1'b0, 16'h1234, 16'hA5C3, 1, -1);
    // R6 R7: plain write, one wait state
    do_txn(1'b1, 16'h4321, 16'h0F0F, 1, -1);
    // R8: wait-state count variants
    do_txn(1'b0, 16'h0001, 16'h7E81, 0, -1);
    do_txn(1'b1, 16'hFFFE, 16'hBEEF, 3, -1);
    // R9: ready stretches strobe
    do_txn(1'b0, 16'h2222, 16'h3C3C, 1, 5);
    do_txn(1'b0, 16'h3333, 16'hC3C3, 1, 9);
    do_txn(1'b1, 16'h4444, 16'h5555, 0, 3);
    // R10: ready low released before the decision sample is ignored
    do_txn(1'b0, 16'h6666, 16'h9999, 1, 1);
    do_txn(1'b1, 16'h7777, 16'h1111, 2, 6);

    // R11: request while busy is ignored
    push_exp(1'b0, 16'h0ABC, 16'h2468, 3, -1);
    bus_rd_val = 16'h2468; wait_cnt = 3'd3;
    while (!req_ready) @(negedge clk);
    req = 1'b1; req_we = 1'b0; req_addr = 16'h0ABC;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    req = 1'b1; req_addr = 16'hDEAD; req_we = 1'b1;
    repeat (3) @(negedge clk);
    req = 1'b0;
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 busy request dropped", exp_q.size(), 0);

    // R12: request held through the done tick
    push_exp(1'b1, 16'h1357, 16'h2468, 0, -1);
    push_exp(1'b0, 16'h9BDF, 16'h8642, 1, -1);
    wait_cnt = 3'd0;
    req = 1'b1; req_we = 1'b1; req_addr = 16'h1357; req_wdata = 16'h2468;
    @(negedge clk);
    while (!done) @(negedge clk);
    req_we = 1'b0; req_addr = 16'h9BDF; bus_rd_val = 16'h8642; wait_cnt = 3'd1;
    gap = 0;
    while (!ale) begin
      @(negedge clk);
      gap++;
    end
    req = 1'b0;
    chk(gap == 2, "R12 back-to-back gap", gap, 2);
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 R12 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule